// File: doc/BRIEF.md
# Button-to-LED Handshake Sequencer

This block is a small hardware node in a closed-loop request/acknowledge exchange with a controlling processor. It sends and receives words through a pair of one-word mailboxes. When a debounced button goes from low to high, the node sends a four-byte "button pressed" message and waits for a grant acknowledge. After that acknowledge it writes the shared LED output and sends an "LEDs set" message. It then waits for a second acknowledge and goes back to idle. The node may change the LEDs only after it has been granted access and before it announces that it is done.

Every message is a null-terminated four-character ASCII string packed little-endian into a 32-bit word. A negative acknowledge, a reply addressed to another node, or silence longer than a set cycle count makes the node send its pending message again. After a fixed number of failed attempts it gives up and raises an error pulse.

Top module: `btn_led_seq`

## Requirements
- R1: After reset `led_o` is 0, `tx_valid_o` is 0, `rx_ready_o` is 0 and `err_o` is 0.
- R2: In idle, a low-to-high change on any button makes the node send the press message. The word carries 'B' (0x42) in bits [7:0], the ASCII digit '0'+NODE_ID in bits [15:8], '0' (0x30) in bits [23:16] and 0x00 in bits [31:24].
- R3: `tx_valid_o` stays high and `tx_word_o` stays unchanged until `tx_ready_i` is seen high.
- R4: `rx_ready_o` is high only while the node waits for an acknowledge, and never in the same cycle as `tx_valid_o`.
- R5: An accepted acknowledge is 'A' (0x41), digit '0'+NODE_ID, 'A', 0x00, in bits [7:0] up to [31:24]. After the first one, the LEDs take the rising-edge button mask (zero-extended) that started the transaction. The node then sends the ready message: 'L' (0x4C), the node digit, '0', 0x00.
- R6: `led_o` changes only at the edge that leaves the LED-write state that follows the first acknowledge.
- R7: Any received word that is not an accepted acknowledge counts as a rejection and makes the node send its pending message again. This covers type 'N' (0x4E) and a digit other than this node's.
- R8: After MAX_TRY failed attempts for one message, the node returns to idle and raises `err_o` for exactly one cycle. The LEDs keep their value.
- R9: While waiting, TIMEOUT cycles with no reply count as a rejection, so the pending message goes out again TIMEOUT cycles after its handshake.
- R10: Button changes during a transaction are ignored. They neither change the LED value nor start a new transaction later.
- R11: After the second acknowledge the node returns to idle and sends nothing until the next press.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_i | input | NUM_BTN | Debounced button levels |
| led_o | output | LED_W | Shared LED drive |
| tx_word_o | output | 32 | Outgoing message word |
| tx_valid_o | output | 1 | Outgoing word valid |
| tx_ready_i | input | 1 | Outgoing mailbox accepts the word |
| rx_word_i | input | 32 | Incoming message word |
| rx_valid_i | input | 1 | Incoming word valid |
| rx_ready_o | output | 1 | Node accepts an incoming word |
| err_o | output | 1 | One-cycle pulse when the node gives up |

## Verification
The bench sends a negative acknowledge and an acknowledge carrying another node's digit. A decoder that checked only the type letter would accept the second one, and would move the LEDs or finish too early. The bench also checks that the resend after a timeout comes exactly TIMEOUT cycles after the handshake, and that a third rejection ends the transaction with a single error pulse and no fourth send. An off-by-one counter would shift the resend or allow an extra attempt. It presses a second button in the middle of a transaction, which a design that latched presses would turn into a wrong LED value or an unrequested message afterwards. It also holds the LEDs under watch while the node waits for the grant, which catches a design that writes them too early.

// File: rtl/btn_led_seq_pkg.sv
package btn_led_seq_pkg;

  localparam logic [7:0] CH_ACK  = 8'h41;
  localparam logic [7:0] CH_BTN  = 8'h42;
  localparam logic [7:0] CH_LED  = 8'h4C;
  localparam logic [7:0] CH_ZERO = 8'h30;
  localparam logic [7:0] CH_NUL  = 8'h00;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_TXB   = 3'd1,
    ST_WAITG = 3'd2,
    ST_SET   = 3'd3,
    ST_TXL   = 3'd4,
    ST_WAITD = 3'd5
  } seq_state_t;

  // Pack a string of three characters and a terminator, first char lowest.
  function automatic logic [31:0] pack_msg(input logic [7:0] kind,
                                           input logic [7:0] digit,
                                           input logic [7:0] data);
    return {CH_NUL, data, digit, kind};
  endfunction

endpackage

// File: rtl/btn_edge_detect.sv
module btn_edge_detect #(
  parameter int NUM_BTN = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_BTN-1:0] btn_i,
  output logic [NUM_BTN-1:0] rise_o,
  output logic               any_rise_o
);
  logic [NUM_BTN-1:0] btn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) btn_q <= '0;
    else        btn_q <= btn_i;
  end

  assign rise_o     = btn_i & ~btn_q;
  assign any_rise_o = |rise_o;
endmodule

// File: rtl/msg_codec.sv
module msg_codec
  import btn_led_seq_pkg::*;
#(
  parameter int NODE_ID = 0
) (
  input  logic        sel_led_i,
  input  logic [31:0] rx_word_i,
  output logic [31:0] tx_word_o,
  output logic        ack_ok_o
);
  localparam logic [7:0] NODE_CH = CH_ZERO + 8'(NODE_ID);

  assign tx_word_o = sel_led_i ? pack_msg(CH_LED, NODE_CH, CH_ZERO)
                               : pack_msg(CH_BTN, NODE_CH, CH_ZERO);

  assign ack_ok_o = (rx_word_i == pack_msg(CH_ACK, NODE_CH, CH_ACK));
endmodule

// File: rtl/retry_ctl.sv
module retry_ctl #(
  parameter int TIMEOUT = 1024,
  parameter int MAX_TRY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic waiting_i,
  input  logic clr_try_i,
  input  logic inc_try_i,
  output logic timeout_o,
  output logic last_try_o
);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam int CW = $clog2(MAX_TRY + 1);
  localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT - 1);
  localparam logic [CW-1:0] C_LAST = CW'(MAX_TRY - 1);

  logic [TW-1:0] tmr_q, tmr_d;
  logic [CW-1:0] try_q, try_d;
  logic          tmr_en, try_en;

  always_comb begin
    tmr_en = 1'b1;
    tmr_d  = waiting_i ? tmr_q + 1'b1 : '0;
    try_en = clr_try_i | inc_try_i;
    try_d  = clr_try_i ? '0 : try_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmr_q <= '0;
    else if (tmr_en) tmr_q <= tmr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      try_q <= '0;
    else if (try_en) try_q <= try_d;
  end

  assign timeout_o  = waiting_i && (tmr_q == T_LAST);
  assign last_try_o = (try_q == C_LAST);
endmodule

// File: rtl/btn_led_seq.sv
module btn_led_seq
  import btn_led_seq_pkg::*;
#(
  parameter int NODE_ID = 0,
  parameter int NUM_BTN = 2,
  parameter int LED_W   = 4,
  parameter int TIMEOUT = 1024,
  parameter int MAX_TRY = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_BTN-1:0] btn_i,
  output logic [LED_W-1:0]   led_o,
  output logic [31:0]        tx_word_o,
  output logic               tx_valid_o,
  input  logic               tx_ready_i,
  input  logic [31:0]        rx_word_i,
  input  logic               rx_valid_i,
  output logic               rx_ready_o,
  output logic               err_o
);
  seq_state_t         state_q, state_d;
  logic [NUM_BTN-1:0] rise, mask_q;
  logic [LED_W-1:0]   led_q, led_val;
  logic               any_rise, ack_ok, timeout, last_try;
  logic               waiting, clr_try, inc_try, err_set, err_q;
  logic               mask_en, led_en;

  btn_edge_detect #(.NUM_BTN(NUM_BTN)) u_edge (
    .clk(clk), .rst_n(rst_n), .btn_i(btn_i),
    .rise_o(rise), .any_rise_o(any_rise));

  msg_codec #(.NODE_ID(NODE_ID)) u_codec (
    .sel_led_i(state_q == ST_TXL), .rx_word_i(rx_word_i),
    .tx_word_o(tx_word_o), .ack_ok_o(ack_ok));

  retry_ctl #(.TIMEOUT(TIMEOUT), .MAX_TRY(MAX_TRY)) u_retry (
    .clk(clk), .rst_n(rst_n), .waiting_i(waiting),
    .clr_try_i(clr_try), .inc_try_i(inc_try),
    .timeout_o(timeout), .last_try_o(last_try));

  generate
    if (LED_W > NUM_BTN) begin : g_pad
      assign led_val = {{(LED_W-NUM_BTN){1'b0}}, mask_q};
    end else begin : g_cut
      assign led_val = mask_q[LED_W-1:0];
    end
  endgenerate

  assign waiting = (state_q == ST_WAITG) || (state_q == ST_WAITD);

  always_comb begin
    state_d = state_q;
    clr_try = 1'b0;
    inc_try = 1'b0;
    err_set = 1'b0;
    mask_en = 1'b0;
    led_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (any_rise) begin
        mask_en = 1'b1;
        clr_try = 1'b1;
        state_d = ST_TXB;
      end
      ST_TXB:  if (tx_ready_i) state_d = ST_WAITG;
      ST_TXL:  if (tx_ready_i) state_d = ST_WAITD;
      ST_SET: begin
        led_en  = 1'b1;
        clr_try = 1'b1;
        state_d = ST_TXL;
      end
      ST_WAITG, ST_WAITD: begin
        if (rx_valid_i && ack_ok) begin
          state_d = (state_q == ST_WAITG) ? ST_SET : ST_IDLE;
        end else if (rx_valid_i || timeout) begin
          if (last_try) begin
            err_set = 1'b1;
            state_d = ST_IDLE;
          end else begin
            inc_try = 1'b1;
            state_d = (state_q == ST_WAITG) ? ST_TXB : ST_TXL;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      led_q <= '0;
    else if (led_en) led_q <= led_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_set;
  end

  assign led_o      = led_q;
  assign err_o      = err_q;
  assign tx_valid_o = (state_q == ST_TXB) || (state_q == ST_TXL);
  assign rx_ready_o = waiting;
endmodule

// File: rtl/btn_led_seq_chk.sv
module btn_led_seq_chk
  import btn_led_seq_pkg::*;
#(
  parameter int LED_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LED_W-1:0] led_o,
  input logic [31:0]      tx_word_o,
  input logic             tx_valid_o,
  input logic             tx_ready_i,
  input logic             rx_ready_o,
  input logic             err_o,
  input seq_state_t       state_q
);
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_word_o))); // R3

  AST_RX_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid_o && rx_ready_o)); // R4

  AST_LED_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(led_o) |-> ($past(state_q) == ST_SET && tx_valid_o)); // R6

  AST_ERR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o); // R8

  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!tx_valid_o && !rx_ready_o && $past(rx_ready_o))); // R8
endmodule

bind btn_led_seq btn_led_seq_chk #(.LED_W(LED_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .led_o(led_o), .tx_word_o(tx_word_o),
  .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i),
  .rx_ready_o(rx_ready_o), .err_o(err_o), .state_q(state_q));

// File: tb/btn_led_seq_test.sv
`timescale 1ns/1ps
module btn_led_seq_test;
  localparam int TO = 16;
  localparam logic [31:0] W_B    = 32'h0030_3142;
  localparam logic [31:0] W_L    = 32'h0030_314C;
  localparam logic [31:0] W_ACK  = 32'h0041_3141;
  localparam logic [31:0] W_NACK = 32'h004E_314E;
  localparam logic [31:0] W_OTH  = 32'h0041_3041;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] btn = '0;
  logic [3:0] led;
  logic [31:0] tx_word, rx_word = '0;
  logic tx_valid, tx_ready = 1'b0, rx_valid = 1'b0, rx_ready, err;
  int checks = 0, errors = 0, err_seen = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  btn_led_seq #(.NODE_ID(1), .NUM_BTN(2), .LED_W(4), .TIMEOUT(TO), .MAX_TRY(3)) uut (
    .clk(clk), .rst_n(rst_n), .btn_i(btn), .led_o(led),
    .tx_word_o(tx_word), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .rx_word_i(rx_word), .rx_valid_i(rx_valid), .rx_ready_o(rx_ready), .err_o(err));

  always @(posedge clk) if (rst_n && err) err_seen++;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic press(input logic [1:0] m);
    @(negedge clk) btn = m;
    tick();
    @(negedge clk) btn = '0;
  endtask

  // wait for a send, check word, hold ready low two cycles, then accept
  task automatic take_tx(input logic [31:0] exp, input string tag);
    int n = 0;
    while (!tx_valid && n < 40) begin tick(); n++; end
    chk(tx_valid, tag, 32'(tx_valid), 32'd1);
    chk(tx_word == exp, tag, tx_word, exp);
    tick(); tick();
    chk(tx_valid && tx_word == exp, "R3 hold", tx_word, exp);
    chk(!rx_ready, "R4 no rx during tx", 32'(rx_ready), 32'd0);
    @(negedge clk) tx_ready = 1'b1;
    tick();
    @(negedge clk) tx_ready = 1'b0;
  endtask

  task automatic reply(input logic [31:0] w);
    int n = 0;
    while (!rx_ready && n < 40) begin tick(); n++; end
    chk(rx_ready, "R4 rx ready in wait", 32'(rx_ready), 32'd1);
    @(negedge clk) begin rx_valid = 1'b1; rx_word = w; end
    tick();
    @(negedge clk) begin rx_valid = 1'b0; rx_word = '0; end
  endtask

  task automatic quiet(input int cyc, input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < cyc; i++) begin tick(); if (tx_valid) seen = 1'b1; end
    chk(!seen, tag, 32'(seen), 32'd0);
  endtask

  task automatic t_reset();
    chk(led == 0, "R1 led", 32'(led), 0);
    chk(!tx_valid && !rx_ready && !err, "R1 ctrl", {29'd0, tx_valid, rx_ready, err}, 0);
  endtask

  task automatic t_normal(input logic [1:0] m, input logic [3:0] prev);
    press(m);
    take_tx(W_B, "R2 press msg");
    tick(); tick();
    chk(led == prev, "R6 led before grant", 32'(led), 32'(prev));
    reply(W_ACK);
    take_tx(W_L, "R5 ready msg");
    chk(led == {2'b00, m}, "R5 led value", 32'(led), 32'({2'b00, m}));
    reply(W_ACK);
    chk(!tx_valid && !rx_ready, "R11 idle", {30'd0, tx_valid, rx_ready}, 0);
    quiet(20, "R11 no send");
  endtask

  task automatic t_reject();
    int e0 = err_seen;
    press(2'b01);
    take_tx(W_B, "R2 first");
    reply(W_NACK);
    take_tx(W_B, "R7 resend after N");
    reply(W_OTH);
    take_tx(W_B, "R7 resend after wrong digit");
    chk(led == 4'h2, "R6 led held", 32'(led), 32'h2);
    reply(W_ACK);
    take_tx(W_L, "R5 after retries");
    reply(W_NACK);
    take_tx(W_L, "R7 resend L");
    reply(W_ACK);
    chk(led == 4'h1 && err_seen == e0, "R7 finish", 32'(led), 32'h1);
  endtask

  task automatic t_giveup();
    int e0 = err_seen;
    press(2'b10);
    take_tx(W_B, "R2 b");
    reply(W_NACK);
    take_tx(W_B, "R8 try2");
    reply(W_NACK);
    take_tx(W_B, "R8 try3");
    reply(W_NACK);
    tick();
    chk(err_seen == e0 + 1, "R8 err pulse", 32'(err_seen - e0), 1);
    chk(led == 4'h1, "R8 led kept", 32'(led), 32'h1);
    quiet(20, "R8 no fourth try");
  endtask

  task automatic t_timeout();
    int e0 = err_seen;
    int n;
    press(2'b01);
    take_tx(W_B, "R9 b");
    for (int k = 0; k < 2; k++) begin
      n = 0;
      while (!tx_valid && n < 100) begin tick(); n++; end
      chk(n == TO, "R9 resend delay", 32'(n), 32'(TO));
      take_tx(W_B, "R9 resend");
    end
    for (int i = 0; i < TO + 2; i++) tick();
    chk(err_seen == e0 + 1, "R9 err after timeouts", 32'(err_seen - e0), 1);
    quiet(10, "R9 idle");
  endtask

  task automatic t_ignore();
    press(2'b01);
    take_tx(W_B, "R10 b");
    press(2'b10);
    reply(W_ACK);
    take_tx(W_L, "R10 l");
    chk(led == 4'h1, "R10 led from first press", 32'(led), 32'h1);
    @(negedge clk) btn = 2'b10;
    reply(W_ACK);
    @(negedge clk) btn = 2'b00;
    quiet(20, "R10 no late transaction");
  endtask

  initial begin
    #1;
    t_reset();
    tick(); tick();
    @(negedge clk) rst_n = 1'b1;
    tick();
    t_reset();
    t_normal(2'b10, 4'h0);
    t_normal(2'b01, 4'h2);
    t_normal(2'b10, 4'h1);
    t_reject();
    t_giveup();
    t_timeout();
    t_ignore();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule